// File: doc/BRIEF.md
# Majority-Vote Asynchronous Receiver

This block recovers bytes from an asynchronous serial line that carries 10-bit frames: a low start bit, eight data bits sent least significant bit first, and one stop bit. A one-cycle baud tick at sixteen times the bit rate drives a phase counter. Each bit is decided from three samples taken around its centre. A start bit whose voted value is high is treated as noise and dropped.

The decoded byte goes into a single holding buffer. The line has no ready signal that can stall it, so the output side works as a valid/acknowledge pair with loss instead of stall. `rx_full` is the valid flag. `rx_clear` is the host's acknowledge. While `rx_full` is high, any frame that completes is thrown away and the held byte is kept. When multiprocessor filtering is on, a frame loads only if its stop bit is high.

Top module: `mv_uart_rx`

## Requirements
- R1: A frame start is accepted only while `rx_en` is 1. With `rx_en` at 0, a complete frame on `rxd` leaves `rx_full`, `rx_data` and `rx_stop` unchanged.
- R2: After the line passes through a two-stage synchronizer, a 1-to-0 change between consecutive baud ticks starts a frame. The eight data bits that follow are assembled least significant bit first into `rx_data`.
- R3: The phase counter restarts on the detected edge. That edge tick is tick 0. Each bit is sampled on ticks 7, 8 and 9 of its 16-tick period, and the bit takes the majority of the three samples. One disagreeing sample does not change the bit. Two disagreeing samples do.
- R4: If the voted start bit is 1, the frame is abandoned and the receiver again waits for a falling edge.
- R5: When `mp_mode` is 1, a frame whose stop bit votes 0 is not loaded. A frame whose stop bit votes 1 is loaded.
- R6: When `rx_full` is already 1 at the middle of the stop bit, the frame is lost: `rx_data`, `rx_stop` and `rx_full` keep their values.
- R7: On a load, `rx_stop` takes the voted stop bit. With `mp_mode` at 0, this includes a stop bit of 0.
- R8: The receiver is back in hunt after the stop bit's tick 9. A start edge on the next tick (tick 10 of the stop bit) begins a new frame.
- R9: `rx_full` rises on a load and holds until `rx_clear`. `rx_clear` wins over a load in the same cycle. If that load had `rx_full` at 0, the buffer is still written but `rx_full` stays 0.
- R10: After reset, `rx_full`, `rx_data` and `rx_stop` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| rx_en | input | 1 | Arms start detection |
| mp_mode | input | 1 | Multiprocessor filtering: stop bit must be 1 |
| rx_clear | input | 1 | Host acknowledge, clears `rx_full` |
| rx_data | output | 8 | Last accepted byte |
| rx_stop | output | 1 | Stop bit of the last accepted frame |
| rx_full | output | 1 | Buffer holds an unacknowledged byte |

## Verification
The host acknowledge and the stop-bit load can land on the same clock edge. The bench provokes this by raising `rx_clear` exactly on the baud tick that carries sample 9 of the stop bit.

It does so twice. In the first run `rx_full` is already set: the frame must be dropped and the flag must end low. In the second run `rx_full` is clear: the new byte must appear on `rx_data` while `rx_full` stays low.

// File: rtl/mvrx_pkg.sv
package mvrx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/mvrx_sync.sv
module mvrx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/mvrx_sampler.sv
module mvrx_sampler
  import mvrx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int MID = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  input  logic hunt,
  input  logic arm,
  output logic start_det,
  output logic bit_done,
  output logic bit_val
);

  localparam int PW = $clog2(OSR);
  localparam logic [PW-1:0] PH_EARLY = PW'(MID - 2);
  localparam logic [PW-1:0] PH_MID   = PW'(MID - 1);
  localparam logic [PW-1:0] PH_LATE  = PW'(MID);
  localparam logic [PW-1:0] PH_LAST  = PW'(OSR - 1);

  logic [PW-1:0] phase;
  logic          s_early;
  logic          s_mid;
  logic          last_hi;

  assign start_det = tick && hunt && arm && last_hi && !rxd;
  assign bit_done  = tick && !hunt && (phase == PH_LATE);
  assign bit_val   = vote3(s_early, s_mid, rxd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      s_early <= 1'b0;
      s_mid   <= 1'b0;
      last_hi <= 1'b0;
    end else if (tick) begin
      last_hi <= rxd;
      if (start_det) begin
        phase <= '0;
      end else if (!hunt) begin
        phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        if (phase == PH_EARLY) s_early <= rxd;
        if (phase == PH_MID)   s_mid   <= rxd;
      end
    end
  end

endmodule

// File: rtl/mvrx_frame.sv
module mvrx_frame
  import mvrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              bit_done,
  input  logic              bit_val,
  input  logic              mp_mode,
  input  logic              clr,
  output logic              hunt,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_stop,
  output logic              rx_full
);

  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

  rx_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [CW-1:0]     cnt;
  logic              load_ok;

  assign hunt    = (state == ST_HUNT);
  assign load_ok = (state == ST_STOP) && bit_done && !rx_full && (!mp_mode || bit_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HUNT;
      shreg <= '0;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_HUNT:  if (start_det) state <= ST_START;
        ST_START: if (bit_done) begin
          cnt   <= '0;
          state <= bit_val ? ST_HUNT : ST_DATA;
        end
        ST_DATA:  if (bit_done) begin
          shreg <= {bit_val, shreg[DATA_W-1:1]};
          cnt   <= cnt + 1'b1;
          if (cnt == LAST_BIT) state <= ST_STOP;
        end
        ST_STOP:  if (bit_done) state <= ST_HUNT;
        default:  state <= ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_stop <= 1'b0;
      rx_full <= 1'b0;
    end else begin
      if (load_ok) begin
        rx_data <= shreg;
        rx_stop <= bit_val;
      end
      if (clr)          rx_full <= 1'b0;
      else if (load_ok) rx_full <= 1'b1;
    end
  end

  // R9: an acknowledge always leaves the flag low on the next cycle
  p_clear_wins_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !rx_full);

  // R6: a held byte is never overwritten
  p_hold_while_full_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |=> $stable(rx_data) && $stable(rx_stop));

  // R5: filtered loads only carry a high stop bit
  p_mp_stop_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_full) && $past(mp_mode)) |-> rx_stop);

  // R4: the receiver only leaves hunt for the start state
  p_hunt_exit_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT) |=> (state == ST_HUNT || state == ST_START));

endmodule

// File: rtl/mv_uart_rx.sv
module mv_uart_rx
  import mvrx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SAMPLE_MID  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              mp_mode,
  input  logic              rx_clear,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_stop,
  output logic              rx_full
);

  logic rxd_s;
  logic hunt;
  logic start_det;
  logic bit_done;
  logic bit_val;

  mvrx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rxd),
    .q     (rxd_s)
  );

  mvrx_sampler #(.OSR(OSR), .MID(SAMPLE_MID)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .rxd       (rxd_s),
    .hunt      (hunt),
    .arm       (rx_en),
    .start_det (start_det),
    .bit_done  (bit_done),
    .bit_val   (bit_val)
  );

  mvrx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .bit_done  (bit_done),
    .bit_val   (bit_val),
    .mp_mode   (mp_mode),
    .clr       (rx_clear),
    .hunt      (hunt),
    .rx_data   (rx_data),
    .rx_stop   (rx_stop),
    .rx_full   (rx_full)
  );

  // R1: a disarmed receiver that is hunting stays hunting
  p_disarmed_idle_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    (hunt && !rx_en) |=> hunt);

endmodule

// File: tb/mv_uart_rx_bench.sv
module mv_uart_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick = 1'b0;
  logic       rxd;
  logic       rx_en;
  logic       mp_mode;
  logic       rx_clear;
  logic [7:0] rx_data;
  logic       rx_stop;
  logic       rx_full;
  logic       mon_clr = 1'b0;
  logic       drv_clr;
  logic       full_prev = 1'b0;
  int         tcnt = 0;

  int         n_cmp = 0;
  int         n_bad = 0;
  logic [8:0] exp_q[$];
  bit         auto_clr;
  bit         done = 1'b0;

  assign rx_clear = mon_clr | drv_clr;

  mv_uart_rx u_mv_uart_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .rxd       (rxd),
    .rx_en     (rx_en),
    .mp_mode   (mp_mode),
    .rx_clear  (rx_clear),
    .rx_data   (rx_data),
    .rx_stop   (rx_stop),
    .rx_full   (rx_full)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tcnt      <= (tcnt == TICK_DIV-1) ? 0 : tcnt + 1;
    baud_tick <= (tcnt == TICK_DIV-1);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares every rising rx_full against the queue
  always @(negedge clk) begin
    mon_clr   <= 1'b0;
    full_prev <= rx_full;
    if (rst_n === 1'b1 && rx_full && !full_prev) begin
      if (exp_q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R2 unexpected load actual=%0h expected=none", {rx_stop, rx_data});
      end else begin
        chk("R2/R7 scoreboard byte", {23'd0, rx_stop, rx_data}, {23'd0, exp_q.pop_front()});
      end
      if (auto_clr) mon_clr <= 1'b1;
    end
  end

  task automatic slot(input logic v);
    do @(posedge clk); while (!baud_tick);
    @(negedge clk);
    rxd = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1);
  endtask

  // mode 1: slot 7 of each data bit inverted; mode 2: slots 7 and 8 of data bit 0 inverted
  task automatic send_frame(input logic [7:0] d, input logic stopv, input int mode,
                            input bit clr_at_stop, input int stop_slots);
    for (int b = 0; b < 10; b++) begin
      for (int j = 0; j < ((b == 9) ? stop_slots : 16); j++) begin
        logic v;
        v = (b == 0) ? 1'b0 : (b == 9) ? stopv : d[b-1];
        if (mode == 1 && b >= 1 && b <= 8 && j == 7) v = ~v;
        if (mode == 2 && b == 1 && (j == 7 || j == 8)) v = ~v;
        slot(v);
        if (clr_at_stop && b == 9 && j == 9) begin
          repeat (TICK_DIV-1) @(negedge clk);
          drv_clr = 1'b1;
          @(negedge clk);
          drv_clr = 1'b0;
        end
      end
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] pat[5];
    pat = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h81};
    rxd = 1'b1; rx_en = 1'b1; mp_mode = 1'b0; drv_clr = 1'b0; auto_clr = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 rx_full", {31'd0, rx_full}, 32'd0);
    chk("R10 rx_data", {24'd0, rx_data}, 32'd0);
    chk("R10 rx_stop", {31'd0, rx_stop}, 32'd0);
    idle(20);

    // R2 plain frames, LSB first
    foreach (pat[i]) begin
      exp_q.push_back({1'b1, pat[i]});
      send_frame(pat[i], 1'b1, 0, 1'b0, 16);
      idle(4);
    end
    chk("R2 all frames seen", exp_q.size(), 0);

    // R3 single minority sample per bit, then a two-sample flip of bit 0
    exp_q.push_back({1'b1, 8'hC6});
    send_frame(8'hC6, 1'b1, 1, 1'b0, 16);
    idle(4);
    exp_q.push_back({1'b1, 8'h5B ^ 8'h01});
    send_frame(8'h5B, 1'b1, 2, 1'b0, 16);
    idle(4);
    chk("R3 votes seen", exp_q.size(), 0);

    // R4 false start: low for only six ticks
    for (int i = 0; i < 6; i++) slot(1'b0);
    idle(40);
    chk("R4 no load from glitch", {31'd0, rx_full}, 32'd0);
    exp_q.push_back({1'b1, 8'h77});
    send_frame(8'h77, 1'b1, 0, 1'b0, 16);
    idle(4);
    chk("R4 frame after glitch", {24'd0, rx_data}, 32'h77);

    // R7 stop bit 0 accepted without filtering
    exp_q.push_back({1'b0, 8'h4E});
    send_frame(8'h4E, 1'b0, 0, 1'b0, 16);
    idle(20);
    chk("R7 stop captured", {31'd0, rx_stop}, 32'd0);

    // R5 filtering
    mp_mode = 1'b1;
    send_frame(8'h9D, 1'b0, 0, 1'b0, 16);
    idle(20);
    chk("R5 filtered data", {24'd0, rx_data}, 32'h4E);
    chk("R5 filtered flag", {31'd0, rx_full}, 32'd0);
    exp_q.push_back({1'b1, 8'hD9});
    send_frame(8'hD9, 1'b1, 0, 1'b0, 16);
    idle(4);
    mp_mode = 1'b0;

    // R8 back-to-back with stop cut at tick 10
    exp_q.push_back({1'b1, 8'h12});
    send_frame(8'h12, 1'b1, 0, 1'b0, 10);
    exp_q.push_back({1'b1, 8'h34});
    send_frame(8'h34, 1'b1, 0, 1'b0, 16);
    idle(4);
    chk("R8 both frames seen", exp_q.size(), 0);

    // R1 disarmed
    rx_en = 1'b0;
    send_frame(8'h5A, 1'b1, 0, 1'b0, 16);
    idle(4);
    chk("R1 flag", {31'd0, rx_full}, 32'd0);
    chk("R1 data", {24'd0, rx_data}, 32'h34);
    rx_en = 1'b1;
    idle(4);

    // R6 byte lost while full
    auto_clr = 1'b0;
    exp_q.push_back({1'b1, 8'h11});
    send_frame(8'h11, 1'b1, 0, 1'b0, 16);
    idle(4);
    chk("R6 flag set", {31'd0, rx_full}, 32'd1);
    send_frame(8'h22, 1'b0, 0, 1'b0, 16);
    idle(20);
    chk("R6 data kept", {24'd0, rx_data}, 32'h11);
    chk("R6 stop kept", {31'd0, rx_stop}, 32'd1);
    chk("R6 flag kept", {31'd0, rx_full}, 32'd1);

    // R9 clear on the stop-middle tick, flag set: frame lost, flag cleared
    send_frame(8'h66, 1'b1, 0, 1'b1, 16);
    idle(4);
    chk("R9 flag cleared", {31'd0, rx_full}, 32'd0);
    chk("R9 data kept", {24'd0, rx_data}, 32'h11);
    // R9 clear on the stop-middle tick, flag clear: data loads, flag stays low
    send_frame(8'h33, 1'b1, 0, 1'b1, 16);
    idle(4);
    chk("R9 flag low", {31'd0, rx_full}, 32'd0);
    chk("R9 data loaded", {24'd0, rx_data}, 32'h33);
    chk("R9 stop loaded", {31'd0, rx_stop}, 32'd1);

    chk("R2 queue empty at end", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule